// File: doc/BRIEF.md
# Video RAM Block Copy Engine

This block moves data into the video RAM window (0x8000 to 0x9FFF) in units of 16 bytes. Software loads a 16-bit source address and a 16-bit destination address into four byte registers. It then writes a control byte, and that write launches the copy. In immediate mode the whole requested length is copied in one burst, and the processor is held off for the whole burst. In line-gap mode the engine copies one 16-byte unit each time the display raises its blank-start pulse. A control byte of this kind is a common way to feed tile or map data during horizontal blanking.

The engine reads one byte on its read port and writes it to the write port on the following cycle, so each byte takes two cycles. When a run ends, the engine writes its final addresses back into the address registers. It then updates the control byte so that software can follow progress. The blank-start pulse comes from the display logic and is not produced here.

Top module: `vramDma`

## Requirements
- R1: After reset the control register reads 0xFF, the address registers read 0x00, `cpuStall` is low and neither memory strobe is active.
- R2: The source address is {reg 0, reg 1} with its low 4 bits cleared. The read address rises by one for each byte.
- R3: The destination address is 0x8000 OR ({reg 2, reg 3} AND 0x1FF0). It rises by one per byte and wraps from 0x9FFF to 0x8000, so it never leaves the video RAM window.
- R4: A control write whose source address, after its low 4 bits are cleared, lies in 0x8000 to 0x9FFF is ignored. No transfer starts and the control register keeps its value.
- R5: The control register is register 4. In a control write, bit 7 = 0 selects immediate mode and bits [6:0] = n ask for (n+1)×16 bytes. In immediate mode the whole length is copied right away, whatever the video mode. `cpuStall` is high for exactly 2 cycles per byte.
- R6: When an immediate-mode run ends, the control register reads 0xFF.
- R7: When any run ends, registers 0 to 3 hold the next source and destination addresses, high byte first.
- R8: A control write with bit 7 = 1 arms line-gap mode. The control register then reads bits [6:0] with bit 7 cleared. If line-gap mode was not already armed and the video mode is not 0, nothing is copied at once. Each rising edge of `blankStart` while armed and idle copies exactly one 16-byte unit. Holding `blankStart` high does not repeat the copy.
- R9: Each finished line-gap unit decrements the control register. When it wraps from 0x00 to 0xFF, line-gap mode ends and later `blankStart` edges copy nothing.
- R10: A line-gap arm written while the video mode is 0 copies its first unit at once.
- R11: A control write with bit 7 = 0 while line-gap mode is armed and the video mode is not 0 disarms line-gap mode and copies nothing.
- R12: While `cpuStall` is high, all register writes are ignored.
- R13: Each byte written equals the byte returned for the read issued one cycle earlier. Read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register index for the write: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 3 | Register index for the read; indexes 5 to 7 read 0xFF |
| regRdData | output | 8 | Register read data, combinational |
| videoMode | input | 2 | Current display mode; 0 means horizontal blank |
| blankStart | input | 1 | Line-gap trigger; its rising edge requests one unit |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 16 | Memory read address |
| memRdData | input | 8 | Read data, valid the cycle after `memRdEn` |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 16 | Memory write address, always inside 0x8000 to 0x9FFF |
| memWrData | output | 8 | Memory write data |
| cpuStall | output | 1 | Holds the processor off while a run is in progress |

## Verification
Immediate runs are tried at three lengths. They use unaligned register values, which shows whether the low bits are masked, and one destination that starts near the top of the window, which separates wrapping from overflow. The line-gap trials arm the engine in the display's drawing mode, then send a series of pulses, one of them held high. This distinguishes triggering on the edge from triggering on the level and follows the counter down through its wrap. Further patterns arm the engine during blanking, disarm it with a plain control write, start from a source inside video RAM, and write registers while a run is in progress. Each of these singles out one start decision or one gating rule.

// File: rtl/vramDmaPkg.sv
package vramDmaPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } dmaStateT;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic busy;      // a run is in progress
    logic armPtrs;   // accepted control write: load pointers and control byte
    logic runAll;    // start a run of the full requested length
    logic runOne;    // start a run of a single unit
    logic step;      // one byte has been written
    logic endRun;    // the last byte of the run is being written
    logic endBlank;  // the run that ends belongs to line-gap mode
  } dmaStrobeT;

  localparam logic [2:0] REG_SRC_HI = 3'd0;
  localparam logic [2:0] REG_SRC_LO = 3'd1;
  localparam logic [2:0] REG_DST_HI = 3'd2;
  localparam logic [2:0] REG_DST_LO = 3'd3;
  localparam logic [2:0] REG_CTRL   = 3'd4;

endpackage

// File: rtl/vramDmaCtrl.sv
module vramDmaCtrl
  import vramDmaPkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regWrAddr,
  input  logic              modeBit,
  input  logic [MODE_W-1:0] videoMode,
  input  logic              blankStart,
  input  logic              srcBad,
  input  logic              lastByte,
  input  logic              ctrlZero,
  output dmaStrobeT         stb,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              cpuStall
);

  dmaStateT stateQ;
  logic     blankOnQ;
  logic     blankPrevQ;

  logic ctrlHit;
  logic startNow;
  logic blankEdge;
  logic trigger;

  assign ctrlHit   = regWrEn && (regWrAddr == REG_CTRL) && (stateQ == ST_IDLE) && !srcBad;
  assign startNow  = (!blankOnQ && !modeBit) || (videoMode == '0);
  assign blankEdge = blankStart && !blankPrevQ;
  assign trigger   = (stateQ == ST_IDLE) && !ctrlHit && blankOnQ && blankEdge;

  always_comb begin
    stb          = '0;
    stb.busy     = (stateQ != ST_IDLE);
    stb.armPtrs  = ctrlHit;
    stb.runAll   = ctrlHit && startNow && !modeBit;
    stb.runOne   = (ctrlHit && startNow && modeBit) || trigger;
    stb.step     = (stateQ == ST_WRITE);
    stb.endRun   = (stateQ == ST_WRITE) && lastByte;
    stb.endBlank = blankOnQ;
  end

  assign memRdEn  = (stateQ == ST_READ);
  assign memWrEn  = (stateQ == ST_WRITE);
  assign cpuStall = stb.busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      blankOnQ   <= 1'b0;
      blankPrevQ <= 1'b0;
    end else begin
      blankPrevQ <= blankStart;
      unique case (stateQ)
        ST_IDLE:  if (stb.runAll || stb.runOne) stateQ <= ST_READ;
        ST_READ:  stateQ <= ST_WRITE;
        ST_WRITE: stateQ <= lastByte ? ST_IDLE : ST_READ;
        default:  stateQ <= ST_IDLE;
      endcase
      if (ctrlHit) begin
        blankOnQ <= modeBit;
      end else if (stb.endRun && blankOnQ && ctrlZero) begin
        blankOnQ <= 1'b0;
      end
    end
  end

  AST_EXCLUSIVE_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R13

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> memWrEn); // R13

  AST_DISARM_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.endRun && blankOnQ && ctrlZero && !ctrlHit) |=> !blankOnQ); // R9

endmodule

// File: rtl/vramDmaPath.sv
module vramDmaPath
  import vramDmaPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int UNIT_BITS = 4,
  parameter int WIN_BITS  = 13,
  parameter int WIN_BASE  = 'h8000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dmaStrobeT             stb,
  input  logic                  regWrEn,
  input  logic [2:0]            regWrAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [2:0]            regRdAddr,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [2*DATA_W-1:0]   memRdAddr,
  output logic [2*DATA_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]     memWrData,
  output logic                  srcBad,
  output logic                  lastByte,
  output logic                  ctrlZero
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int LEN_W  = DATA_W - 1;
  localparam int TAG_W  = ADDR_W - WIN_BITS;
  localparam int N_ADDR_REGS = 4;
  localparam logic [ADDR_W-1:0] WIN_BASE_V = ADDR_W'(WIN_BASE);
  localparam logic [TAG_W-1:0]  WIN_TAG    = WIN_BASE_V[ADDR_W-1:WIN_BITS];

  logic [DATA_W-1:0]   addrRegQ [N_ADDR_REGS];
  logic [DATA_W-1:0]   ctrlQ;
  logic [ADDR_W-1:0]   srcPtrQ;
  logic [WIN_BITS-1:0] dstOffQ;
  logic [UNIT_BITS-1:0] byteCntQ;
  logic [LEN_W:0]      unitsLeftQ;

  logic [ADDR_W-1:0]   reqSrc;
  logic [ADDR_W-1:0]   reqDstRaw;
  logic [WIN_BITS-1:0] reqDstOff;
  logic [ADDR_W-1:0]   nxtSrc;
  logic [ADDR_W-1:0]   nxtDst;
  logic [DATA_W-1:0]   nxtBytes [N_ADDR_REGS];

  // requested addresses, aligned to a unit
  assign reqSrc    = {addrRegQ[REG_SRC_HI], addrRegQ[REG_SRC_LO][DATA_W-1:UNIT_BITS], {UNIT_BITS{1'b0}}};
  assign reqDstRaw = {addrRegQ[REG_DST_HI], addrRegQ[REG_DST_LO]};
  assign reqDstOff = {reqDstRaw[WIN_BITS-1:UNIT_BITS], {UNIT_BITS{1'b0}}};
  assign srcBad    = (reqSrc[ADDR_W-1:WIN_BITS] == WIN_TAG);

  // addresses that follow the byte now being written
  assign nxtSrc = srcPtrQ + 1'b1;
  assign nxtDst = {WIN_TAG, dstOffQ + 1'b1};
  assign nxtBytes[REG_SRC_HI] = nxtSrc[ADDR_W-1:DATA_W];
  assign nxtBytes[REG_SRC_LO] = nxtSrc[DATA_W-1:0];
  assign nxtBytes[REG_DST_HI] = nxtDst[ADDR_W-1:DATA_W];
  assign nxtBytes[REG_DST_LO] = nxtDst[DATA_W-1:0];

  assign lastByte = (byteCntQ == '1) && (unitsLeftQ == (LEN_W+1)'(1));
  assign ctrlZero = (ctrlQ == '0);

  assign memRdAddr = srcPtrQ;
  assign memWrAddr = {WIN_TAG, dstOffQ};
  assign memWrData = memRdData;

  // address byte registers: software write when idle, write-back at run end
  for (genvar i = 0; i < N_ADDR_REGS; i++) begin : g_addrReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrRegQ[i] <= '0;
      end else if (stb.endRun) begin
        addrRegQ[i] <= nxtBytes[i];
      end else if (regWrEn && !stb.busy && (regWrAddr == 3'(i))) begin
        addrRegQ[i] <= regWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '1;
    end else if (stb.endRun) begin
      ctrlQ <= stb.endBlank ? ctrlQ - 1'b1 : '1;
    end else if (stb.armPtrs) begin
      ctrlQ <= regWrData[DATA_W-1] ? {1'b0, regWrData[LEN_W-1:0]} : regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtrQ    <= '0;
      dstOffQ    <= '0;
      byteCntQ   <= '0;
      unitsLeftQ <= '0;
    end else begin
      if (stb.armPtrs) begin
        srcPtrQ <= reqSrc;
        dstOffQ <= reqDstOff;
      end else if (stb.step) begin
        srcPtrQ <= nxtSrc;
        dstOffQ <= dstOffQ + 1'b1;
      end
      if (stb.runAll) begin
        unitsLeftQ <= {1'b0, regWrData[LEN_W-1:0]} + 1'b1;
        byteCntQ   <= '0;
      end else if (stb.runOne) begin
        unitsLeftQ <= (LEN_W+1)'(1);
        byteCntQ   <= '0;
      end else if (stb.step) begin
        byteCntQ <= byteCntQ + 1'b1;
        if (byteCntQ == '1) unitsLeftQ <= unitsLeftQ - 1'b1;
      end
    end
  end

  always_comb begin
    unique case (regRdAddr)
      REG_SRC_HI: regRdData = addrRegQ[REG_SRC_HI];
      REG_SRC_LO: regRdData = addrRegQ[REG_SRC_LO];
      REG_DST_HI: regRdData = addrRegQ[REG_DST_HI];
      REG_DST_LO: regRdData = addrRegQ[REG_DST_LO];
      REG_CTRL:   regRdData = ctrlQ;
      default:    regRdData = '1;
    endcase
  end

  AST_REGS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && $past(stb.busy)) |-> ($stable(ctrlQ) && $stable(addrRegQ[REG_SRC_HI])
                                       && $stable(addrRegQ[REG_DST_HI]))); // R12

  AST_UNITS_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (unitsLeftQ != '0)); // R5

endmodule

// File: rtl/vramDma.sv
module vramDma
  import vramDmaPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int UNIT_BITS = 4,
  parameter int WIN_BITS  = 13,
  parameter int WIN_BASE  = 'h8000,
  parameter int MODE_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regWrAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [2:0]          regRdAddr,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [MODE_W-1:0]   videoMode,
  input  logic                blankStart,
  output logic                memRdEn,
  output logic [2*DATA_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                memWrEn,
  output logic [2*DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic                cpuStall
);

  dmaStrobeT stb;
  logic srcBad;
  logic lastByte;
  logic ctrlZero;

  vramDmaCtrl #(.MODE_W(MODE_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .modeBit   (regWrData[DATA_W-1]),
    .videoMode (videoMode),
    .blankStart(blankStart),
    .srcBad    (srcBad),
    .lastByte  (lastByte),
    .ctrlZero  (ctrlZero),
    .stb       (stb),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .cpuStall  (cpuStall)
  );

  vramDmaPath #(
    .DATA_W   (DATA_W),
    .UNIT_BITS(UNIT_BITS),
    .WIN_BITS (WIN_BITS),
    .WIN_BASE (WIN_BASE)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .regRdAddr (regRdAddr),
    .regRdData (regRdData),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .srcBad    (srcBad),
    .lastByte  (lastByte),
    .ctrlZero  (ctrlZero)
  );

  AST_STALL_COVERS_TRAFFIC: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> cpuStall); // R5

  AST_SOURCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memWrEn)) |-> (memRdAddr == $past(memRdAddr, 2) + 1'b1)); // R2

  AST_DEST_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn, 2) && cpuStall) |->
      ((memWrAddr[WIN_BITS-1:0] == $past(memWrAddr[WIN_BITS-1:0], 2) + 1'b1)
       && (memWrAddr[2*DATA_W-1:WIN_BITS] == $past(memWrAddr[2*DATA_W-1:WIN_BITS], 2)))); // R3

endmodule

// File: tb/test_vramDma.sv
module test_vramDma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [7:0]  regRdData;
  logic [1:0]  videoMode = 2'd2;
  logic        blankStart = 1'b0;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic        memWrEn;
  logic [15:0] memWrAddr;
  logic [7:0]  memWrData;
  logic        cpuStall;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [23:0] wrLog [0:1023];

  always #2.5 clk = ~clk;

  vramDma i_vramDma (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .videoMode(videoMode), .blankStart(blankStart), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .cpuStall(cpuStall)
  );

  function automatic logic [7:0] srcByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // memory model: read data one cycle after the strobe; write logger
  always @(posedge clk) begin
    if (memRdEn) memRdData <= srcByte(memRdAddr);
    if (memWrEn && wrCount < 1024) begin
      wrLog[wrCount] <= {memWrAddr, memWrData};
    end
    if (memWrEn) wrCount <= wrCount + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic checkReg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    readReg(a, d);
    check(req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic loadAddrs(input logic [15:0] src, input logic [15:0] dst);
    writeReg(3'd0, src[15:8]);
    writeReg(3'd1, src[7:0]);
    writeReg(3'd2, dst[15:8]);
    writeReg(3'd3, dst[7:0]);
  endtask

  // count stall cycles from the current falling edge on
  task automatic countStall(output int cnt);
    cnt = 0;
    while (cpuStall && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic checkRun(input string req, input int base, input int n,
                          input logic [15:0] src, input logic [15:0] dst);
    int bad = -1;
    check({req, " byte count"}, wrCount - base, n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ea;
      logic [15:0] sa;
      ea = 16'h8000 | ((dst + 16'(i)) & 16'h1FFF);
      sa = src + 16'(i);
      if (bad < 0 && wrLog[base + i] !== {ea, srcByte(sa)}) bad = i;
    end
    if (bad >= 0) begin
      check({req, " write stream"}, {8'd0, wrLog[base + bad]},
            {8'd0, 16'h8000 | ((dst + 16'(bad)) & 16'h1FFF), srcByte(src + 16'(bad))});
    end else begin
      check({req, " write stream"}, 0, 0);
    end
  endtask

  task automatic pulseBlank(output int cnt);
    @(negedge clk);
    blankStart = 1'b1;
    @(negedge clk);
    countStall(cnt);
    repeat (3) @(negedge clk);
    blankStart = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 control after reset", {24'd0, 8'hFF}, 32'hFF);
    checkReg("R1 control reg", 3'd4, 8'hFF);
    checkReg("R1 source high reg", 3'd0, 8'h00);
    check("R1 stall low", {31'd0, cpuStall}, 0);
    check("R1 strobes idle", {30'd0, memRdEn, memWrEn}, 0);
  endtask

  task automatic testGeneral();
    int base; int cnt;
    videoMode = 2'd2;
    loadAddrs(16'h1234, 16'h9A5F);
    base = wrCount;
    writeReg(3'd4, 8'h02);
    countStall(cnt);
    @(negedge clk);
    check("R5 stall cycles for 48 bytes", cnt, 96);
    checkRun("R2 R3 R13 general run", base, 48, 16'h1230, 16'h9A50);
    checkReg("R6 control after general run", 3'd4, 8'hFF);
    checkReg("R7 source high write-back", 3'd0, 8'h12);
    checkReg("R7 source low write-back", 3'd1, 8'h60);
    checkReg("R7 dest high write-back", 3'd2, 8'h9A);
    checkReg("R7 dest low write-back", 3'd3, 8'h80);
  endtask

  task automatic testBusyWrites();
    int base; int cnt;
    loadAddrs(16'h2000, 16'h8000);
    base = wrCount;
    writeReg(3'd4, 8'h00);
    writeReg(3'd0, 8'h77);
    writeReg(3'd4, 8'h05);
    countStall(cnt);
    @(negedge clk);
    check("R12 run length unchanged by busy control write", wrCount - base, 16);
    checkReg("R12 source high not overwritten", 3'd0, 8'h20);
    checkReg("R12 control not overwritten", 3'd4, 8'hFF);
  endtask

  task automatic testWrap();
    int base; int cnt;
    loadAddrs(16'h0500, 16'h1FF0);
    base = wrCount;
    writeReg(3'd4, 8'h01);
    countStall(cnt);
    @(negedge clk);
    check("R5 stall cycles for 32 bytes", cnt, 64);
    checkRun("R3 window wrap run", base, 32, 16'h0500, 16'h9FF0);
    checkReg("R3 R7 dest high after wrap", 3'd2, 8'h80);
    checkReg("R3 R7 dest low after wrap", 3'd3, 8'h10);
  endtask

  task automatic testBadSource();
    int base;
    loadAddrs(16'h9FFF, 16'h8000);
    base = wrCount;
    writeReg(3'd4, 8'h03);
    repeat (6) @(negedge clk);
    check("R4 no writes from video RAM source", wrCount - base, 0);
    check("R4 no stall", {31'd0, cpuStall}, 0);
    checkReg("R4 control unchanged", 3'd4, 8'hFF);
  endtask

  task automatic testBlank();
    int base; int cnt;
    videoMode = 2'd3;
    loadAddrs(16'h4007, 16'h8123);
    base = wrCount;
    writeReg(3'd4, 8'h82);
    repeat (6) @(negedge clk);
    check("R8 armed without copy", wrCount - base, 0);
    checkReg("R8 control shows length", 3'd4, 8'h02);
    base = wrCount;
    pulseBlank(cnt);
    check("R8 one unit stall", cnt, 32);
    checkRun("R8 first unit (held trigger)", base, 16, 16'h4000, 16'h8120);
    checkReg("R9 control after first unit", 3'd4, 8'h01);
    checkReg("R7 source low after unit", 3'd1, 8'h10);
    checkReg("R7 dest low after unit", 3'd3, 8'h30);
    base = wrCount;
    pulseBlank(cnt);
    checkRun("R8 second unit", base, 16, 16'h4010, 16'h8130);
    checkReg("R9 control after second unit", 3'd4, 8'h00);
    base = wrCount;
    pulseBlank(cnt);
    checkRun("R9 third unit", base, 16, 16'h4020, 16'h8140);
    checkReg("R9 control wraps", 3'd4, 8'hFF);
    base = wrCount;
    pulseBlank(cnt);
    check("R9 no copy after wrap", wrCount - base, 0);
  endtask

  task automatic testBlankImmediate();
    int base; int cnt;
    videoMode = 2'd0;
    loadAddrs(16'h3000, 16'h8000);
    base = wrCount;
    writeReg(3'd4, 8'h81);
    countStall(cnt);
    @(negedge clk);
    check("R10 immediate unit stall", cnt, 32);
    checkRun("R10 immediate unit", base, 16, 16'h3000, 16'h8000);
    checkReg("R10 control after immediate unit", 3'd4, 8'h00);
    videoMode = 2'd3;
    base = wrCount;
    pulseBlank(cnt);
    checkRun("R10 follow-up unit", base, 16, 16'h3010, 16'h8010);
    checkReg("R9 control wraps after follow-up", 3'd4, 8'hFF);
  endtask

  task automatic testCancel();
    int base; int cnt;
    videoMode = 2'd3;
    loadAddrs(16'h5000, 16'h8800);
    base = wrCount;
    writeReg(3'd4, 8'h83);
    writeReg(3'd4, 8'h05);
    repeat (6) @(negedge clk);
    check("R11 disarm copies nothing", wrCount - base, 0);
    checkReg("R11 control holds written value", 3'd4, 8'h05);
    pulseBlank(cnt);
    check("R11 trigger ignored after disarm", wrCount - base, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGeneral();
    testBusyWrites();
    testWrap();
    testBadSource();
    testBlank();
    testBlankImmediate();
    testCancel();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule